// File: doc/BRIEF.md
# Multiplexed LED Display Scanner with Refresh Watchdog

This block scans a front panel of LEDs and keys by time multiplexing. The panel is split into four strobe columns. While a column holds the scan, the block drives that column's select line together with two seven-segment digits (called even and odd) and seven indicator lamps. At the end of that column's slot it samples six key inputs. The scan steps through columns 0, 1, 2, 3 and then starts again, with a fixed dwell of `DWELL` clock cycles per column. For the last `GUARD` cycles of every dwell, all segment and lamp lines are forced off so that a pattern does not ghost into the next column. Every drive line is active low, the way a latched driver stage expects it: a zero lights the LED.

A host writes the pattern for each column through an addressed write port into a staging bank. A column's staged pattern is copied into the live drivers only at the moment that column becomes selected. A write therefore never changes the column that is lit at that time. Key samples are gathered into a 24-bit key map that the host can read at any time.

The scan advances only while `scan_run` is high. Every column change counts as a strobe update and restarts a refresh watchdog. If no strobe update happens for `WD_PERIODS` column periods, the watchdog trips and every drive line, including the strobes, goes high (off). Drive returns on the first strobe update after the trip.

The control state machine has three states. ST_LIT drives the current column's pattern. ST_GUARD blanks segments and lamps while the strobe stays on. ST_DARK turns everything off. The transitions are:
- LIT_TO_GUARD: the dwell count reaches `DWELL-GUARD-1` while running.
- GUARD_TO_LIT: a column advance.
- LIT_TO_DARK and GUARD_TO_DARK: the watchdog is about to trip.
- DARK_TO_LIT: the first column advance after the trip.

Top module: `disp_scan`

## Requirements
- R1: After reset, column 0 is selected (`strobe_n` = 4'b1110), all segment and lamp lines read all ones, every staged and live pattern is all ones, and `key_map` is zero.
- R2: While `scan_run` stays high, each column is selected for exactly `DWELL` cycles, in the order 0, 1, 2, 3, 0. The selected column has `strobe_n[col]` = 0 and every other strobe bit = 1.
- R3: During the final `GUARD` cycles of each dwell (dwell count >= `DWELL-GUARD`), `seg_even_n`, `seg_odd_n` and `lamp_n` are all ones while the strobe stays on.
- R4: The write address is {column, selector}. Selector 0 writes the even digit, 1 the odd digit and 2 the lamps. Selector 3 is ignored. Bit 0 of a digit pattern is segment a, and a 0 bit lights its LED. Outside the guard window, the outputs show the selected column's live pattern.
- R5: A pattern write takes effect at the next time its column becomes selected. A write to the lit column does not change its outputs during the current dwell. The value loaded is the one staged before the advancing clock edge.
- R6: On the last cycle of a column's dwell, `key_in[k]` is stored into `key_map[col*6+k]`. All other key map bits keep their values.
- R7: While `scan_run` is low, the dwell count and the column are frozen, so no strobe update happens.
- R8: After `WD_PERIODS*DWELL` consecutive cycles without a strobe update, every strobe, segment and lamp line goes high.
- R9: After a watchdog trip, drive returns on the first strobe update. That update selects the column that follows the frozen one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_run | input | 1 | Scan advance enable; low freezes the scan |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | 4 | {column[1:0], selector[1:0]} |
| wr_data | input | 7 | Pattern value, active low |
| key_in | input | 6 | Key lines of the selected column, 1 = pressed |
| strobe_n | output | 4 | Column selects, active low |
| seg_even_n | output | 7 | Even digit segments a..g, active low |
| seg_odd_n | output | 7 | Odd digit segments a..g, active low |
| lamp_n | output | 7 | Indicator lamps, active low |
| key_map | output | 24 | Sampled key map, bit col*6+key |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and settle well before each rising edge.
- `scan_run` may fall or rise on any cycle, including inside the guard window.
- Writes may target any address, including the ignored selector and the column that is lit at the time.

The stimulus changes every input on the falling clock edge. It drops `scan_run` once for less than the watchdog window and once for longer than it. It holds the key lines constant across one full scan and otherwise changes them every cycle.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
    typedef enum logic [1:0] {
        ST_LIT   = 2'd0,
        ST_GUARD = 2'd1,
        ST_DARK  = 2'd2
    } scan_state_t;

    localparam logic [1:0] SEL_EVEN = 2'd0;
    localparam logic [1:0] SEL_ODD  = 2'd1;
    localparam logic [1:0] SEL_LAMP = 2'd2;
endpackage

// File: rtl/dscan_timer.sv
module dscan_timer #(
    parameter int NCOL  = 4,
    parameter int DWELL = 1024,
    parameter int GUARD = 8,
    localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int DCW  = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [CW-1:0] col,
    output logic [CW-1:0] col_next,
    output logic          advance,
    output logic          guard_entry,
    output logic          guard_zone
);
    logic [DCW-1:0] cnt_q;
    logic [CW-1:0]  col_q;

    assign col         = col_q;
    assign col_next    = (col_q == CW'(NCOL - 1)) ? '0 : col_q + CW'(1);
    assign advance     = run && (cnt_q == DCW'(DWELL - 1));
    assign guard_entry = run && (cnt_q == DCW'(DWELL - GUARD - 1));
    assign guard_zone  = (cnt_q >= DCW'(DWELL - GUARD));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            col_q <= '0;
        end else if (advance) begin
            cnt_q <= '0;
            col_q <= col_next;
        end else if (run) begin
            cnt_q <= cnt_q + DCW'(1);
        end
    end

    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(col_q)); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/dscan_wdog.sv
module dscan_wdog #(
    parameter int LIMIT = 8192,
    localparam int WW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic trip_next,
    output logic tripped
);
    logic [WW-1:0] wd_q;

    assign tripped   = (wd_q == WW'(LIMIT));
    assign trip_next = !kick && (wd_q == WW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            wd_q <= '0;
        end else if (!tripped) begin
            wd_q <= wd_q + WW'(1);
        end
    end

    AST_WD_RECOVER: assert property (@(posedge clk) disable iff (rst)
        kick |=> !tripped); // R9
endmodule

// File: rtl/dscan_bank.sv
module dscan_bank
    import dscan_pkg::*;
#(
    parameter int NCOL  = 4,
    parameter int SEGW  = 7,
    parameter int LAMPW = 7,
    localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int DW   = (SEGW > LAMPW) ? SEGW : LAMPW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_col,
    input  logic [1:0]       wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             load,
    input  logic [CW-1:0]    load_col,
    output logic [SEGW-1:0]  live_even,
    output logic [SEGW-1:0]  live_odd,
    output logic [LAMPW-1:0] live_lamp
);
    logic [SEGW-1:0]  even_arr [NCOL];
    logic [SEGW-1:0]  odd_arr  [NCOL];
    logic [LAMPW-1:0] lamp_arr [NCOL];

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [SEGW-1:0]  even_r;
        logic [SEGW-1:0]  odd_r;
        logic [LAMPW-1:0] lamp_r;
        logic             hit;

        assign hit = wr_en && (wr_col == CW'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                even_r <= '1;
                odd_r  <= '1;
                lamp_r <= '1;
            end else if (hit) begin
                unique case (wr_sel)
                    SEL_EVEN: even_r <= wr_data[SEGW-1:0];
                    SEL_ODD:  odd_r  <= wr_data[SEGW-1:0];
                    SEL_LAMP: lamp_r <= wr_data[LAMPW-1:0];
                    default:  ;
                endcase
            end
        end

        assign even_arr[c] = even_r;
        assign odd_arr[c]  = odd_r;
        assign lamp_arr[c] = lamp_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_even <= '1;
            live_odd  <= '1;
            live_lamp <= '1;
        end else if (load) begin
            live_even <= even_arr[load_col];
            live_odd  <= odd_arr[load_col];
            live_lamp <= lamp_arr[load_col];
        end
    end

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(live_even) && $stable(live_odd) && $stable(live_lamp))); // R5
endmodule

// File: rtl/dscan_keys.sv
module dscan_keys #(
    parameter int NCOL = 4,
    parameter int NKEY = 6,
    localparam int CW  = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int KMW = NCOL * NKEY
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample,
    input  logic [CW-1:0]   col,
    input  logic [NKEY-1:0] key_in,
    output logic [KMW-1:0]  key_map
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [NKEY-1:0] map_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                map_r <= '0;
            end else if (sample && (col == CW'(c))) begin
                map_r <= key_in;
            end
        end

        assign key_map[c*NKEY +: NKEY] = map_r;
    end

    AST_KEYS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(key_map)); // R6
endmodule

// File: rtl/disp_scan.sv
module disp_scan
    import dscan_pkg::*;
#(
    parameter int NCOL       = 4,
    parameter int NKEY       = 6,
    parameter int SEGW       = 7,
    parameter int LAMPW      = 7,
    parameter int DWELL      = 1024,
    parameter int GUARD      = 8,
    parameter int WD_PERIODS = 8,
    localparam int CW        = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int AW        = CW + 2,
    localparam int DW        = (SEGW > LAMPW) ? SEGW : LAMPW,
    localparam int KMW       = NCOL * NKEY,
    localparam int WD_LIMIT  = WD_PERIODS * DWELL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_run,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [NKEY-1:0]  key_in,
    output logic [NCOL-1:0]  strobe_n,
    output logic [SEGW-1:0]  seg_even_n,
    output logic [SEGW-1:0]  seg_odd_n,
    output logic [LAMPW-1:0] lamp_n,
    output logic [KMW-1:0]   key_map
);
    logic [CW-1:0]    col;
    logic [CW-1:0]    col_next;
    logic             advance;
    logic             guard_entry;
    logic             guard_zone;
    logic             trip_next;
    logic             wd_tripped;
    logic [SEGW-1:0]  live_even;
    logic [SEGW-1:0]  live_odd;
    logic [LAMPW-1:0] live_lamp;
    scan_state_t      state_q;
    scan_state_t      state_d;

    dscan_timer #(.NCOL(NCOL), .DWELL(DWELL), .GUARD(GUARD)) u_timer (
        .clk(clk), .rst(rst), .run(scan_run),
        .col(col), .col_next(col_next), .advance(advance),
        .guard_entry(guard_entry), .guard_zone(guard_zone)
    );

    dscan_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk(clk), .rst(rst), .kick(advance),
        .trip_next(trip_next), .tripped(wd_tripped)
    );

    dscan_bank #(.NCOL(NCOL), .SEGW(SEGW), .LAMPW(LAMPW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_col(wr_addr[AW-1:2]), .wr_sel(wr_addr[1:0]), .wr_data(wr_data),
        .load(advance), .load_col(col_next),
        .live_even(live_even), .live_odd(live_odd), .live_lamp(live_lamp)
    );

    dscan_keys #(.NCOL(NCOL), .NKEY(NKEY)) u_keys (
        .clk(clk), .rst(rst), .sample(advance), .col(col),
        .key_in(key_in), .key_map(key_map)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIT: begin
                if (trip_next)        state_d = ST_DARK;
                else if (guard_entry) state_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (trip_next)        state_d = ST_DARK;
                else if (advance)     state_d = ST_LIT;
            end
            ST_DARK: begin
                if (advance)          state_d = ST_LIT;
            end
            default:                  state_d = ST_LIT;
        endcase
    end

    always_comb begin
        strobe_n   = '1;
        seg_even_n = '1;
        seg_odd_n  = '1;
        lamp_n     = '1;
        unique case (state_q)
            ST_LIT: begin
                strobe_n   = ~(NCOL'(1) << col);
                seg_even_n = live_even;
                seg_odd_n  = live_odd;
                lamp_n     = live_lamp;
            end
            ST_GUARD: strobe_n = ~(NCOL'(1) << col);
            ST_DARK:  ;
            default:  ;
        endcase
    end

    AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~strobe_n)); // R2
    AST_GUARD_BLANK: assert property (@(posedge clk) disable iff (rst)
        guard_zone |-> (&seg_even_n && &seg_odd_n && &lamp_n)); // R3
    AST_DARK_OFF: assert property (@(posedge clk) disable iff (rst)
        wd_tripped |-> (&strobe_n && &seg_even_n && &seg_odd_n && &lamp_n)); // R8
endmodule

// File: tb/disp_scan_test.sv
module disp_scan_test;
    localparam int DWELL = 1024;
    localparam int GUARD = 8;
    localparam int WDL   = 8 * DWELL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_run = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic [5:0] key_in = '0;
    logic [3:0] strobe_n;
    logic [6:0] seg_even_n, seg_odd_n, lamp_n;
    logic [23:0] key_map;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    bit key_fixed = 1'b0;
    int cyc = 0;

    // behavioural reference state
    int         m_cnt, m_col, m_wd;
    logic [6:0] m_stage [4][3];
    logic [6:0] m_live [3];
    logic [23:0] m_keys;

    always #10 clk = ~clk;

    disp_scan uut (
        .clk(clk), .rst(rst), .scan_run(scan_run), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .key_in(key_in),
        .strobe_n(strobe_n), .seg_even_n(seg_even_n), .seg_odd_n(seg_odd_n),
        .lamp_n(lamp_n), .key_map(key_map)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    function automatic logic [6:0] pat(input int c, input int s);
        if (s == 0) return 7'(c * 17 + 3);
        if (s == 1) return 7'(c * 29 + 41);
        return 7'(c * 11 + 64);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt <= 0; m_col <= 0; m_wd <= 0; m_keys <= '0;
            for (int c = 0; c < 4; c++)
                for (int s = 0; s < 3; s++) m_stage[c][s] <= 7'h7F;
            for (int s = 0; s < 3; s++) m_live[s] <= 7'h7F;
        end else begin
            if (wr_en && wr_addr[1:0] != 2'd3)
                m_stage[wr_addr[3:2]][wr_addr[1:0]] <= wr_data;
            if (scan_run && m_cnt == DWELL - 1) begin
                for (int s = 0; s < 3; s++) m_live[s] <= m_stage[(m_col + 1) % 4][s];
                m_keys[m_col*6 +: 6] <= key_in;
                m_col <= (m_col + 1) % 4;
                m_cnt <= 0;
                m_wd  <= 0;
            end else begin
                if (scan_run) m_cnt <= m_cnt + 1;
                if (m_wd < WDL) m_wd <= m_wd + 1;
            end
        end
        started <= 1'b1;
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (started && !rst && !done) begin
            bit dark, blank;
            dark  = (m_wd >= WDL);
            blank = dark || (m_cnt >= DWELL - GUARD);
            cmp(dark ? "R8" : "R2", "strobe_n", 32'(strobe_n),
                dark ? 32'hF : 32'(~(4'b1 << m_col) & 4'hF));
            cmp(dark ? "R8" : (blank ? "R3" : "R4"), "seg_even_n", 32'(seg_even_n),
                blank ? 32'h7F : 32'(m_live[0]));
            cmp(dark ? "R8" : (blank ? "R3" : "R4"), "seg_odd_n/lamp_n",
                32'({seg_odd_n, lamp_n}), blank ? 32'h3FFF : 32'({m_live[1], m_live[2]}));
            cmp("R6", "key_map", 32'(key_map), 32'(m_keys));
        end
    end

    always @(negedge clk) begin
        key_in <= key_fixed ? 6'h2D : 6'((cyc * 7) ^ (cyc >> 5));
    end

    task automatic write_reg(input int c, input int s, input logic [6:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'((c << 2) | s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_strobe(input logic [3:0] want);
        for (int i = 0; i < 5000; i++) begin
            if (strobe_n == want) return;
            @(negedge clk);
        end
    endtask

    initial begin
        int fc;
        logic [3:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cmp("R1", "strobe_n", 32'(strobe_n), 32'hE);
        cmp("R1", "seg_even_n", 32'(seg_even_n), 32'h7F);
        cmp("R1", "lamp_n", 32'(lamp_n), 32'h7F);
        cmp("R1", "key_map", 32'(key_map), 32'h0);
        scan_run = 1'b1;
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 3; s++) write_reg(c, s, pat(c, s));
        write_reg(2, 3, 7'h00); // selector 3 must be ignored (R4)
        @(negedge clk);
        // R5: lit column 0 keeps its old pattern
        cmp("R5", "seg_even_n during write", 32'(seg_even_n), 32'h7F);
        wait_strobe(4'b1101);
        repeat (DWELL - GUARD - 1) @(negedge clk);
        cmp("R4", "seg_odd_n col1 last lit cycle", 32'(seg_odd_n), 32'(pat(1, 1)));
        @(negedge clk);
        cmp("R3", "seg_odd_n col1 guard start", 32'(seg_odd_n), 32'h7F);
        wait_strobe(4'b1110);
        @(negedge clk);
        cmp("R5", "seg_even_n col0 reselected", 32'(seg_even_n), 32'(pat(0, 0)));
        // R6: constant keys over a full scan
        key_fixed = 1'b1;
        repeat (4 * DWELL + 8) @(negedge clk);
        cmp("R6", "key_map constant keys", 32'(key_map), {8'h0, {4{6'h2D}}});
        key_fixed = 1'b0;
        // R7: short freeze
        scan_run = 1'b0;
        held = strobe_n;
        repeat (3000) @(negedge clk);
        cmp("R7", "strobe_n frozen", 32'(strobe_n), 32'(held));
        scan_run = 1'b1;
        repeat (1500) @(negedge clk);
        write_reg(3, 0, 7'h2A);
        // R8: freeze beyond the watchdog window
        scan_run = 1'b0;
        held = strobe_n;
        fc = 0;
        for (int i = 0; i < 4; i++) if (!held[i]) fc = i;
        repeat (WDL + 8) @(negedge clk);
        cmp("R8", "strobe_n dark", 32'(strobe_n), 32'hF);
        cmp("R8", "lamp_n dark", 32'(lamp_n), 32'h7F);
        scan_run = 1'b1;
        for (int i = 0; i < 1100 && strobe_n == 4'hF; i++) @(negedge clk);
        cmp("R9", "strobe_n after recovery", 32'(strobe_n),
            32'(~(4'b1 << ((fc + 1) % 4)) & 4'hF));
        for (int c = 0; c < 4; c++) write_reg(c, 2, pat(3 - c, 0));
        repeat (6000) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule